// File: doc/BRIEF.md
# Nibble S-box seed mixer

The block turns an 8-bit random word into an 8-bit seed for a downstream inversion encoder. When an input word is flagged valid, it is stored in a capture register. In the following cycle the stored word is transformed and the result is written to a registered output, together with an output valid flag.

The transformation treats the two halves of the result differently. The lower four bits come from the two nibbles of the stored word. Each nibble passes through the same fixed 4-bit substitution table, and the two substituted values are added with the carry discarded. The upper four bits are the complement of the stored word's upper nibble. The block is therefore not a byte-wide substitution.

The block is a plain two-stage pipeline that accepts a new word every cycle. It has no backpressure. While no word arrives, the output keeps its last value.

Top module: `nsm_seed_mixer`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0 and `out_data` is 8'h00.
- R2: Let `S` be the substitution that maps inputs 0 to F, in order, to C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2. Then `out_data[3:0]` equals (S(w[7:4]) + S(w[3:0])) mod 16, where w is the accepted input word.
- R3: `out_data[7:4]` equals the bitwise complement of w[7:4].
- R4: `out_valid` is high on the second rising edge after the edge that samples `in_valid` high. It stays high for exactly one cycle per accepted word.
- R5: A cycle with `in_valid` low does not change `out_data`, whatever value `in_data` carries.
- R6: When the sum of the two substituted nibbles is 16 or more, the carry is dropped and only the low four bits of the sum appear in `out_data[3:0]`.
- R7: Words presented on consecutive cycles each produce one output, in the order they were presented, with no word lost.
- R8: A reset cancels a word already held in the capture stage, as well as a word presented in the same cycle as the reset. Neither word produces `out_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `in_data` for capture |
| in_data | input | 8 | Random input word |
| out_valid | output | 1 | High for one cycle when `out_data` carries a new seed |
| out_data | output | 8 | Registered seed |

## Verification
The bench sweeps all 256 input words back to back and compares every output with an arithmetic reference model. This catches a wrong table entry, which would corrupt single input values, and swapped halves or a complement taken from the wrong nibble, which would corrupt the upper half for most words. Words whose substituted sum overflows are checked on their own, because an adder that kept its carry in the result would shift or corrupt the low nibble for exactly those words. Idle cycles carry scrambled data to expose a capture register that loads without qualification. A reset that lands while a word is in flight must not let a stale valid pulse leak out.

// File: rtl/nsm_pkg.sv
package nsm_pkg;

   localparam int unsigned NSM_SUBST_W = 4;

   // Substitution packed most-significant entry first: entry 0 is bits 63:60.
   localparam logic [63:0] NSM_SUBST_PACKED = 64'hC56B_90AD_3EF8_4712;

   typedef enum logic {
      SUBST_CASE   = 1'b0,
      SUBST_PACKED = 1'b1
   } nsm_lut_e;

   function automatic logic [NSM_SUBST_W-1:0] nsm_subst_lookup(input logic [NSM_SUBST_W-1:0] x);
      int unsigned base;
      base = 63 - 4 * int'(x);
      return NSM_SUBST_PACKED[base -: 4];
   endfunction

endpackage

// File: rtl/nsm_stage.sv
module nsm_stage #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         ld,
   input  logic [W-1:0] d,
   output logic         vq,
   output logic [W-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         vq <= 1'b0;
         q  <= '0;
      end else begin
         vq <= ld;
         if (ld) q <= d;
      end
   end

endmodule

// File: rtl/nsm_sbox4.sv
module nsm_sbox4
   import nsm_pkg::*;
#(
   parameter nsm_lut_e LUT_STYLE = SUBST_CASE
) (
   input  logic [NSM_SUBST_W-1:0] x,
   output logic [NSM_SUBST_W-1:0] y
);

   generate
      if (LUT_STYLE == SUBST_CASE) begin : g_case
         always_comb begin
            unique case (x)
               4'h0: y = 4'hC;
               4'h1: y = 4'h5;
               4'h2: y = 4'h6;
               4'h3: y = 4'hB;
               4'h4: y = 4'h9;
               4'h5: y = 4'h0;
               4'h6: y = 4'hA;
               4'h7: y = 4'hD;
               4'h8: y = 4'h3;
               4'h9: y = 4'hE;
               4'hA: y = 4'hF;
               4'hB: y = 4'h8;
               4'hC: y = 4'h4;
               4'hD: y = 4'h7;
               4'hE: y = 4'h1;
               default: y = 4'h2;
            endcase
         end
      end else begin : g_packed
         assign y = nsm_subst_lookup(x);
      end
   endgenerate

endmodule

// File: rtl/nsm_mix.sv
module nsm_mix
   import nsm_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned NIB_W     = 4,
   parameter nsm_lut_e    LUT_STYLE = SUBST_CASE
) (
   input  logic [DATA_W-1:0] word,
   output logic [DATA_W-1:0] seed
);

   localparam int unsigned NUM_NIB = DATA_W / NIB_W;
   localparam int unsigned HALF_W  = DATA_W / 2;

   generate
      if (NIB_W != NSM_SUBST_W) begin : g_bad_nib
         $error("nsm_mix: NIB_W must match the 4-bit substitution");
      end
      if (DATA_W != 2 * NIB_W) begin : g_bad_data
         $error("nsm_mix: DATA_W must be two nibbles");
      end
   endgenerate

   logic [NIB_W-1:0] subst [NUM_NIB];
   logic [NIB_W-1:0] acc;

   generate
      for (genvar g = 0; g < NUM_NIB; g++) begin : g_nib
         nsm_sbox4 #(.LUT_STYLE(LUT_STYLE)) u_sbox (
            .x (word[g*NIB_W +: NIB_W]),
            .y (subst[g])
         );
      end
   endgenerate

   // Sum wraps at NIB_W bits: carry is dropped.
   always_comb begin
      acc = '0;
      for (int i = 0; i < NUM_NIB; i++) acc = acc + subst[i];
   end

   wire [DATA_W-1:0] inv_word = ~word;

   assign seed = {inv_word[DATA_W-1 -: HALF_W], acc};

endmodule

// File: rtl/nsm_seed_mixer.sv
module nsm_seed_mixer
   import nsm_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned NIB_W     = 4,
   parameter nsm_lut_e    LUT_STYLE = SUBST_CASE
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);

   logic              cap_v;
   logic [DATA_W-1:0] cap_q;
   logic [DATA_W-1:0] mixed;

   nsm_stage #(.W(DATA_W)) u_capture (
      .clk (clk),
      .rst (rst),
      .ld  (in_valid),
      .d   (in_data),
      .vq  (cap_v),
      .q   (cap_q)
   );

   nsm_mix #(
      .DATA_W    (DATA_W),
      .NIB_W     (NIB_W),
      .LUT_STYLE (LUT_STYLE)
   ) u_mix (
      .word (cap_q),
      .seed (mixed)
   );

   nsm_stage #(.W(DATA_W)) u_result (
      .clk (clk),
      .rst (rst),
      .ld  (cap_v),
      .d   (mixed),
      .vq  (out_valid),
      .q   (out_data)
   );

endmodule

// File: rtl/nsm_seed_mixer_chk.sv
module nsm_seed_mixer_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [DATA_W-1:0] in_data,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_data
);

   localparam int unsigned HALF_W = DATA_W / 2;

   logic              trk_v1, trk_v2;
   logic [DATA_W-1:0] trk_w1, trk_w2;

   always_ff @(posedge clk) begin
      if (rst) begin
         trk_v1 <= 1'b0;
         trk_v2 <= 1'b0;
         trk_w1 <= '0;
         trk_w2 <= '0;
      end else begin
         trk_v1 <= in_valid;
         trk_v2 <= trk_v1;
         if (in_valid) trk_w1 <= in_data;
         if (trk_v1)   trk_w2 <= trk_w1;
      end
   end

   AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!out_valid && out_data == '0)) // R1
      else $error("reset did not clear output");

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst) out_valid == trk_v2) // R4
      else $error("out_valid latency wrong");

   AST_HIGH_NIBBLE: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_data[DATA_W-1 -: HALF_W] == ~trk_w2[DATA_W-1 -: HALF_W])) // R3
      else $error("high nibble not complement");

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      (!trk_v1 && !out_valid) |=> (!out_valid && $stable(out_data))) // R5
      else $error("output changed while idle");

   AST_FLUSH: assert property (@(posedge clk) rst |=> ##1 !out_valid) // R8
      else $error("word survived reset");

endmodule

bind nsm_seed_mixer nsm_seed_mixer_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .in_data   (in_data),
   .out_valid (out_valid),
   .out_data  (out_data)
);

// File: tb/tb_nsm_seed_mixer.sv
`timescale 1ns/1ps
module tb_nsm_seed_mixer;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       out_valid;
   logic [7:0] out_data;

   int checks = 0;
   int errors = 0;
   int seen_valid = 0;
   bit done = 0;

   logic       d1v = 0, d2v = 0;
   logic [7:0] d1d = 0, d2d = 0;
   logic [7:0] held = 0;

   localparam logic [63:0] TBL = 64'hC56B90AD3EF84712;

   always #2.5 clk = ~clk;

   nsm_seed_mixer dut (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   function automatic logic [3:0] sub4(input logic [3:0] x);
      return TBL[63 - 4*int'(x) -: 4];
   endfunction

   function automatic int rawsum(input logic [7:0] w);
      return int'(sub4(w[7:4])) + int'(sub4(w[3:0]));
   endfunction

   function automatic logic [7:0] ref_seed(input logic [7:0] w);
      logic [3:0] hi;
      hi = ~w[7:4];
      return {hi, 4'(rawsum(w) % 16)};
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // One cycle: check the output for the word driven two cycles back, then drive.
   task automatic step(input logic v, input logic [7:0] d, input logic r, input string tag);
      @(negedge clk);
      if (out_valid) seen_valid++;
      chk({tag, " valid"}, int'(out_valid), int'(d2v));
      if (d2v) begin
         held = ref_seed(d2d);
         chk("R2 low nibble", int'(out_data[3:0]), int'(held[3:0]));
         chk("R3 high nibble", int'(out_data[7:4]), int'(held[7:4]));
         if (rawsum(d2d) > 15)
            chk("R6 carry dropped", int'(out_data[3:0]), rawsum(d2d) - 16);
      end else begin
         chk({tag, " data held"}, int'(out_data), int'(held));
      end
      rst = r;
      in_valid = v;
      in_data = d;
      d2v = d1v;
      d2d = d1d;
      d1v = v;
      d1d = d;
      if (r) begin
         d1v = 0;
         d2v = 0;
         held = 8'h00;
      end
   endtask

   initial begin
      // R1: reset state
      step(0, 8'h00, 1, "R1");
      step(0, 8'h00, 1, "R1");
      step(0, 8'h00, 0, "R1");
      @(negedge clk);
      chk("R1 out_valid after reset", int'(out_valid), 0);
      chk("R1 out_data after reset", int'(out_data), 0);

      // R7: exhaustive back-to-back sweep
      seen_valid = 0;
      for (int i = 0; i < 256; i++) step(1, 8'(i), 0, "R7");
      step(0, 8'h5A, 0, "R4");
      step(0, 8'hC3, 0, "R4");
      step(0, 8'h0F, 0, "R4");
      chk("R7 outputs from sweep", seen_valid, 256);

      // R4/R5: gapped words with junk on idle cycles
      for (int i = 0; i < 32; i++) begin
         step(1, 8'(i*37 + 5), 0, "R4");
         step(0, 8'(~(i*37 + 5)), 0, "R5");
         step(0, 8'(i*11 + 200), 0, "R5");
      end

      // R8: reset with words in flight
      step(1, 8'hA5, 0, "R8");
      step(1, 8'h3C, 1, "R8");
      step(0, 8'h77, 0, "R8");
      step(0, 8'h77, 0, "R8");
      step(1, 8'h99, 0, "R8");
      step(0, 8'h00, 0, "R8");
      step(0, 8'h00, 0, "R8");
      step(0, 8'h00, 0, "R8");

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule